// File: doc/BRIEF.md
# Rounding Floating Multiplier

This block multiplies two single-word floating point numbers. Each word holds a sign, an exponent stored with an offset of half its range, and a binary fraction. A negative number is the twos complement of the whole word of its positive counterpart. The two fractions are multiplied as unsigned magnitudes into a product twice as wide as one fraction. That product is normalized with zeros shifted in from the right. When asked, it is then rounded away from zero using the first bit that is dropped. Finally it is packed back into one word with the sign restored.

A caller presents both operands and a rounding request together with a one-cycle start strobe. The product word appears one clock later, marked by a one-cycle done pulse. If the final exponent does not fit its field, the stored exponent wraps by the field's range and sticky flags record the event. These flags keep their value until reset, so a caller can test a whole series of products at once.

Top module: `fmul_round`

## Requirements
- R1: The word layout is sign in the top bit, then an EXP_W-bit exponent biased by 2^(EXP_W-1), then an FRAC_W-bit fraction in the low bits. For the default widths this is sign in bit 35, exponent in bits 34:27 and fraction in bits 26:0. A negative value is the twos complement of the whole positive word.
- R2: A product is captured on every clock edge where `start` is high. `done` is high for exactly the following cycle. `prod` holds its value on every edge where `start` is low.
- R3: When the double-width product of the two fraction magnitudes is zero, `prod` becomes all zeros and no flag changes.
- R4: For a nonzero result, the sign bit of `prod` is the exclusive OR of the operand sign bits.
- R5: A nonzero result is normalized: the top fraction bit of its magnitude is 1. Its biased exponent is Ea + Eb - 2^(EXP_W-1) minus the number of left shifts needed to normalize.
- R6: With `rnd_en` high, the magnitude is increased by one LSB when the first dropped bit after normalization is 1. If this carries out of the fraction, the fraction becomes 1/2 and the exponent goes up by one.
- R7: With `rnd_en` low, the magnitude fraction is the normalized product truncated to FRAC_W bits.
- R8: If the final biased exponent exceeds 2^EXP_W - 1, `flg_trap`, `flg_ovf` and `flg_fov` are set, and the stored exponent is the true one minus 2^EXP_W.
- R9: If the final biased exponent is below 0, `flg_fund` is set together with the three flags of R8, and the stored exponent is the true one plus 2^EXP_W.
- R10: The four flags are sticky: once set, they stay set until reset.
- R11: After reset, `prod`, `done` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | EXP_W+FRAC_W+1 | Multiplicand word |
| op_b | input | EXP_W+FRAC_W+1 | Multiplier word |
| rnd_en | input | 1 | Round the product away from zero |
| start | input | 1 | Capture a product on this edge |
| prod | output | EXP_W+FRAC_W+1 | Result word |
| done | output | 1 | Result valid, one cycle after start |
| flg_trap | output | 1 | Sticky trap request |
| flg_ovf | output | 1 | Sticky general overflow |
| flg_fov | output | 1 | Sticky floating exponent out of range |
| flg_fund | output | 1 | Sticky floating exponent too small |

## Verification
The assertions watch, on every cycle, the rules that do not depend on the numbers: the done timing and hold behaviour, the sign of a nonzero result, the normalization of every nonzero output, the fact that an underflow always comes with the overflow flags, and the fact that flags never clear without reset. The exact fraction bits, the exponent arithmetic, the rounding carry, the wrap by the exponent range and the zero result can only be shown by the bench. It compares every product of a near-exhaustive sweep over a narrow configuration with values it computes arithmetically.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
   typedef struct packed {
      logic trap;
      logic ovf;
      logic fov;
      logic fund;
   } fmul_flags_t;
endpackage

// File: rtl/fmul_unpack.sv
module fmul_unpack #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 27
) (
   input  logic [EXP_W+FRAC_W:0] word_i,
   output logic                  sgn_o,
   output logic [EXP_W-1:0]      exp_o,
   output logic [FRAC_W-1:0]     frac_o
);
   localparam int MW = EXP_W + FRAC_W;

   logic [MW-1:0] mag;

   assign sgn_o  = word_i[MW];
   // low bits of the whole-word negation give the magnitude fields
   assign mag    = sgn_o ? (~word_i[MW-1:0] + 1'b1) : word_i[MW-1:0];
   assign exp_o  = mag[MW-1 -: EXP_W];
   assign frac_o = mag[FRAC_W-1:0];
endmodule

// File: rtl/fmul_lzc.sv
module fmul_lzc #(
   parameter int W  = 54,
   parameter int CW = 6
) (
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] cnt_o
);
   always_comb begin
      cnt_o = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (vec_i[i]) cnt_o = CW'(W - 1 - i);
      end
   end
endmodule

// File: rtl/fmul_norm_round.sv
module fmul_norm_round #(
   parameter int EXP_W     = 8,
   parameter int FRAC_W    = 27,
   parameter int XW        = 16,
   parameter bit HAS_ROUND = 1
) (
   input  logic [2*FRAC_W-1:0]   prod_i,
   input  logic signed [XW-1:0]  exp_i,
   input  logic                  rnd_i,
   output logic [EXP_W+FRAC_W-1:0] mag_o,
   output logic                  ovf_o,
   output logic                  unf_o
);
   localparam int PW = 2 * FRAC_W;
   localparam int CW = $clog2(PW + 1);
   localparam logic signed [XW-1:0] EMAX = XW'((2 ** EXP_W) - 1);

   logic [CW-1:0]         lz;
   logic                  is_zero;
   logic [FRAC_W-1:0]     frac_r;
   logic                  carry;
   logic signed [XW-1:0]  e_fin;

   assign is_zero = (prod_i == '0);

   fmul_lzc #(.W(PW), .CW(CW)) u_lzc (
      .vec_i (prod_i),
      .cnt_o (lz)
   );

   if (HAS_ROUND) begin : g_rnd
      logic [FRAC_W:0] hg;
      logic [FRAC_W:0] sum;
      // normalized high part plus the first dropped bit in hg[0]
      assign hg     = (FRAC_W+1)'((prod_i << lz) >> (FRAC_W - 1));
      assign sum    = {1'b0, hg[FRAC_W:1]} + (FRAC_W+1)'(rnd_i & hg[0]);
      assign carry  = sum[FRAC_W];
      assign frac_r = carry ? sum[FRAC_W:1] : sum[FRAC_W-1:0];
   end else begin : g_trunc
      assign frac_r = FRAC_W'((prod_i << lz) >> FRAC_W);
      assign carry  = 1'b0;
   end

   assign e_fin = exp_i - $signed(XW'(lz)) + $signed(XW'(carry));

   assign ovf_o = !is_zero && (e_fin > EMAX);
   assign unf_o = !is_zero && (e_fin < 0);
   assign mag_o = is_zero ? '0 : {e_fin[EXP_W-1:0], frac_r};
endmodule

// File: rtl/fmul_round.sv
module fmul_round
   import fmul_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int FRAC_W    = 27,
   parameter bit HAS_ROUND = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [EXP_W+FRAC_W:0] op_a,
   input  logic [EXP_W+FRAC_W:0] op_b,
   input  logic                 rnd_en,
   input  logic                 start,
   output logic [EXP_W+FRAC_W:0] prod,
   output logic                 done,
   output logic                 flg_trap,
   output logic                 flg_ovf,
   output logic                 flg_fov,
   output logic                 flg_fund
);
   localparam int WORD_W = 1 + EXP_W + FRAC_W;
   localparam int PW     = 2 * FRAC_W;
   localparam int XW     = EXP_W + $clog2(PW + 1) + 2;
   localparam int BIAS   = 2 ** (EXP_W - 1);

   if (EXP_W < 2 || FRAC_W < 2) begin : g_bad_cfg
      $error("fmul_round: EXP_W and FRAC_W must both be at least 2");
   end

   logic [WORD_W-1:0]   opw [2];
   logic [1:0]          sg;
   logic [EXP_W-1:0]    ex  [2];
   logic [FRAC_W-1:0]   fr  [2];
   logic [PW-1:0]       fprod;
   logic signed [XW-1:0] exp_sum;
   logic [WORD_W-2:0]   mag;
   logic                ovf_ev;
   logic                unf_ev;
   logic [WORD_W-1:0]   pos_w;
   logic [WORD_W-1:0]   res_w;
   fmul_flags_t         flg_q;

   assign opw[0] = op_a;
   assign opw[1] = op_b;

   for (genvar k = 0; k < 2; k++) begin : g_op
      fmul_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
         .word_i (opw[k]),
         .sgn_o  (sg[k]),
         .exp_o  (ex[k]),
         .frac_o (fr[k])
      );
   end

   assign fprod   = PW'(fr[0]) * PW'(fr[1]);
   assign exp_sum = $signed(XW'(ex[0])) + $signed(XW'(ex[1])) - $signed(XW'(BIAS));

   fmul_norm_round #(
      .EXP_W(EXP_W), .FRAC_W(FRAC_W), .XW(XW), .HAS_ROUND(HAS_ROUND)
   ) u_nr (
      .prod_i (fprod),
      .exp_i  (exp_sum),
      .rnd_i  (rnd_en),
      .mag_o  (mag),
      .ovf_o  (ovf_ev),
      .unf_o  (unf_ev)
   );

   assign pos_w = {1'b0, mag};
   assign res_w = (sg[0] ^ sg[1]) ? (~pos_w + 1'b1) : pos_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod  <= '0;
         done  <= 1'b0;
         flg_q <= '0;
      end else begin
         done <= start;
         if (start) begin
            prod       <= res_w;
            flg_q.trap <= flg_q.trap | ovf_ev | unf_ev;
            flg_q.ovf  <= flg_q.ovf  | ovf_ev | unf_ev;
            flg_q.fov  <= flg_q.fov  | ovf_ev | unf_ev;
            flg_q.fund <= flg_q.fund | unf_ev;
         end
      end
   end

   assign flg_trap = flg_q.trap;
   assign flg_ovf  = flg_q.ovf;
   assign flg_fov  = flg_q.fov;
   assign flg_fund = flg_q.fund;
endmodule

// File: rtl/fmul_round_chk.sv
module fmul_round_chk #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 27
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sa,
   input logic                  sb,
   input logic                  start,
   input logic [EXP_W+FRAC_W:0] prod,
   input logic                  done,
   input logic                  flg_trap,
   input logic                  flg_ovf,
   input logic                  flg_fov,
   input logic                  flg_fund
);
   localparam int W = 1 + EXP_W + FRAC_W;

   logic [W-1:0] pmag;
   assign pmag = prod[W-1] ? (~prod + 1'b1) : prod;

   AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);                                             // R2
   AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);                                           // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(prod));                                   // R2
   AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
      (done && prod != '0) |-> (prod[W-1] == ($past(sa) ^ $past(sb)))); // R4
   AST_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
      (done && prod != '0) |-> pmag[FRAC_W-1]);                   // R5
   AST_FOV_SETS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      flg_fov |-> (flg_ovf && flg_trap));                          // R8
   AST_UNDERFLOW_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      flg_fund |-> flg_fov);                                       // R9
   AST_FLAG_RISE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flg_fov) || $rose(flg_fund)) |-> done);               // R8
   AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !($fell(flg_trap) || $fell(flg_ovf) || $fell(flg_fov) || $fell(flg_fund))); // R10
endmodule

bind fmul_round fmul_round_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sa       (op_a[EXP_W+FRAC_W]),
   .sb       (op_b[EXP_W+FRAC_W]),
   .start    (start),
   .prod     (prod),
   .done     (done),
   .flg_trap (flg_trap),
   .flg_ovf  (flg_ovf),
   .flg_fov  (flg_fov),
   .flg_fund (flg_fund)
);

// File: tb/sim_fmul_round.sv
`timescale 1ns/1ps
module sim_fmul_round;
   localparam int EW = 4;
   localparam int FW = 5;
   localparam int W  = 1 + EW + FW;     // 10-bit words
   localparam int B  = 8;               // exponent bias
   localparam int M  = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic         rnd_en = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] prod;
   logic         done;
   logic         flg_trap, flg_ovf, flg_fov, flg_fund;

   int checks = 0;
   int errors = 0;
   bit s_trap, s_ovf, s_fov, s_fund;

   always #2 clk = ~clk;

   fmul_round #(.EXP_W(EW), .FRAC_W(FW), .HAS_ROUND(1)) u0 (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .rnd_en(rnd_en),
      .start(start), .prod(prod), .done(done), .flg_trap(flg_trap),
      .flg_ovf(flg_ovf), .flg_fov(flg_fov), .flg_fund(flg_fund)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // arithmetic reference: R1 layout sign[9] exp[8:5] frac[4:0]
   task automatic model(input int a, input int b, input int r,
                        output int res, output bit of, output bit uf, output string tag);
      int sa, sb, ma, mb, ea, eb, fa, fb, p, n, lz, hi, lo, e, pos;
      sa = (a >> (W-1)) & 1;  sb = (b >> (W-1)) & 1;
      ma = sa ? ((M - a) % M) : a;
      mb = sb ? ((M - b) % M) : b;
      ea = (ma >> FW) & ((1 << EW) - 1);  fa = ma & ((1 << FW) - 1);
      eb = (mb >> FW) & ((1 << EW) - 1);  fb = mb & ((1 << FW) - 1);
      p = fa * fb;
      of = 0; uf = 0;
      if (p == 0) begin res = 0; tag = "R3"; return; end
      n = p; lz = 0;
      while (n < (1 << (2*FW-1))) begin n = n * 2; lz++; end
      hi = n >> FW;  lo = n & ((1 << FW) - 1);
      e  = ea + eb - B - lz;
      tag = (r != 0) ? "R6" : "R7";
      if (r != 0 && lo >= (1 << (FW-1))) begin
         hi++;
         if (hi == (1 << FW)) begin hi = 1 << (FW-1); e++; end
      end
      if (e > (1 << EW) - 1) begin of = 1; tag = "R8"; end
      if (e < 0) begin uf = 1; tag = "R9"; end
      pos = ((e & ((1 << EW) - 1)) << FW) | hi;
      res = (sa ^ sb) ? ((M - pos) % M) : pos;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      s_trap = 0; s_ovf = 0; s_fov = 0; s_fund = 0;
      // R11 reset state
      chk(prod == '0, "R11 prod", int'(prod), 0);
      chk({done, flg_trap, flg_ovf, flg_fov, flg_fund} == '0, "R11 done/flags",
          int'({done, flg_trap, flg_ovf, flg_fov, flg_fund}), 0);
   endtask

   task automatic run_op(input int a, input int b, input int r);
      int exp_res; bit of, uf; string tag; int pm;
      logic [W-1:0] held;
      model(a, b, r, exp_res, of, uf, tag);
      op_a = W'(a); op_b = W'(b); rnd_en = r[0]; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1, "R2 done", int'(done), 1);
      chk(int'(prod) == exp_res, tag, int'(prod), exp_res);
      if (exp_res != 0) begin
         chk(prod[W-1] == (a[W-1] ^ b[W-1]), "R4 sign", int'(prod[W-1]), int'(a[W-1] ^ b[W-1]));
         pm = prod[W-1] ? ((M - int'(prod)) % M) : int'(prod);
         chk(pm[FW-1] == 1'b1, "R5 normalized", pm, exp_res);
      end
      s_trap |= of | uf; s_ovf |= of | uf; s_fov |= of | uf; s_fund |= uf;
      chk({flg_trap, flg_ovf, flg_fov, flg_fund} == {s_trap, s_ovf, s_fov, s_fund},
          uf ? "R9 flags" : (of ? "R8 flags" : "R10 flags"),
          int'({flg_trap, flg_ovf, flg_fov, flg_fund}), int'({s_trap, s_ovf, s_fov, s_fund}));
      held = prod;
      op_a = ~op_a; op_b = ~op_b;
      @(negedge clk);
      chk(done == 1'b0, "R2 done low", int'(done), 0);
      chk(prod == held, "R2 hold", int'(prod), int'(held));
   endtask

   initial begin
      int ea, eb, sa, sb, pa, pb, wa, wb;
      do_reset();
      for (int i = 0; i < (1 << FW); i++) begin
         if ((i % 4) == 0) do_reset();
         for (int j = 0; j < (1 << FW); j++) begin
            for (int r = 0; r < 2; r++) begin
               ea = (i * 3 + j + r) % (1 << EW);
               eb = (j * 7 + i) % (1 << EW);
               sa = (i ^ (j >> 1)) & 1;
               sb = j & 1;
               pa = (ea << FW) | i;
               pb = (eb << FW) | j;
               wa = sa ? ((M - pa) % M) : pa;
               wb = sb ? ((M - pb) % M) : pb;
               run_op(wa, wb, r);
            end
         end
      end
      // directed: rounding carry 0.11000 * 0.10101 -> renormalize (R6)
      do_reset();
      run_op((8 << FW) | 24, (8 << FW) | 21, 1);
      run_op((8 << FW) | 24, (8 << FW) | 21, 0);   // R7 truncation
      run_op((15 << FW) | 31, (15 << FW) | 31, 1); // R8 overflow wrap
      run_op((0 << FW) | 16, (0 << FW) | 16, 0);   // R9 underflow wrap
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule